// File: doc/BRIEF.md
# Overlay Plane Address Shadow Registers

This block holds the address programming for one overlay display plane: a surface base, a panning offset, a line pitch and a small mode word. Software writes the pending copies over a simple register bus. The base and pitch are double-buffered. A write to the base register arms an update. On the next vertical-blank pulse, the pending base and pitch both move into their active copies in one step. The scan-out engine never sees a frame whose base and pitch come from two different programmings.

The block drives the byte address of the first pixel to fetch, which is the active base plus the offset. It also drives the active pitch. In tiled mode the pitch is limited to the tiled maximum. An error flag reports programming that breaks the alignment rules. When 180-degree rotation is used, software loads the offset with the distance from the base to the last pixel of the last unrotated line. The block applies no special handling for rotation.

Top module: `ovl_plane_regs`

## Requirements
- R1: After synchronous reset, every register, `fetch_addr`, `act_stride`, `upd_armed`, `cfg_err` and `reg_rdata` are zero.
- R2: Writing the pitch register (address 2) alone changes only the pending pitch. `act_stride` keeps its value across a vertical-blank pulse unless an update is armed.
- R3: A write to the base register (address 0) sets `upd_armed` on the next clock. `upd_armed` stays set until a vertical blank applies it. It can be read as bit 2 of the mode register (address 3).
- R4: A `vblank` pulse while armed copies the pending base and pending pitch into the active copies. In the same clock, `upd_armed` clears.
- R5: If the base is written several times before vertical blank, the values applied are the newest pending base and pitch.
- R6: A `vblank` pulse while not armed changes neither active copy.
- R7: `fetch_addr` equals the active base plus the 32-bit offset, modulo 2^32. It is registered, so it appears one clock after either term changes. The offset (address 1) takes effect without waiting for vertical blank.
- R8: Pitch bits 5:0 are reserved. They are discarded on write and read back as zero, so every pitch is a multiple of 64 bytes.
- R9: The mode register bit 0 selects tiled (1) or linear (0). In tiled mode, a pending pitch that is not a multiple of 256 sets `cfg_err`. In linear mode, the pitch never sets `cfg_err`.
- R10: In tiled mode, a pending pitch above 16384 bytes sets `cfg_err`, and that pitch is applied as 16384.
- R11: The mode register bit 1 selects 4-byte pixels (1) or 2-byte pixels (0). An offset that is not a multiple of the pixel size sets `cfg_err`, but its low bits still reach `fetch_addr`. `cfg_err` is registered one clock after the pending state.
- R12: If a base write and a `vblank` pulse fall in the same clock while armed, the vertical blank applies the values that were pending before the write. `upd_armed` stays set for the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered readback of the selected register |
| vblank | input | 1 | One-clock vertical-blank pulse |
| fetch_addr | output | 32 | First-pixel byte address |
| act_stride | output | 32 | Active line pitch in bytes |
| upd_armed | output | 1 | Update pending for next vertical blank |
| cfg_err | output | 1 | Misaligned or oversized programming |

## Verification
The pitch is swept over every multiple of 64 up to 19200 bytes, in both memory modes. This separates the 256-byte tiled alignment rule and the 16 KB clamp from linear mode, where no pitch is an error. The low offset bits are swept with both pixel sizes, which separates the 2-byte and 4-byte alignment rules. The same sweep also shows that the low bits still reach the fetch address. Ordered sequences cover the shadow behaviour. A pitch write alone is followed by a blank. Two base writes come before one blank. A base write lands in the same clock as a blank. Together these separate the arming, the newest-value rule and the collision priority.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    RA_BASE   = 2'd0,
    RA_OFFSET = 2'd1,
    RA_PITCH  = 2'd2,
    RA_MODE   = 2'd3
  } reg_sel_e;

  localparam int MODE_TILED_BIT = 0;
  localparam int MODE_PIX4_BIT  = 1;
  localparam int MODE_ARMED_BIT = 2;
endpackage

// File: rtl/ovl_regfile.sv
module ovl_regfile #(
  parameter int DATA_W    = 32,
  parameter int PITCH_LSB = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              armed,
  output logic [DATA_W-1:0] pend_base,
  output logic [DATA_W-1:0] offset,
  output logic [DATA_W-1:0] pend_pitch,
  output logic              tiled,
  output logic              pix4,
  output logic              base_wr,
  output logic [DATA_W-1:0] rdata
);
  import ovl_pkg::*;

  localparam logic [DATA_W-1:0] PITCH_MASK = ~((DATA_W'(1) << PITCH_LSB) - DATA_W'(1));

  reg_sel_e sel;
  assign sel     = reg_sel_e'(addr);
  assign base_wr = wr && (sel == RA_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_base  <= '0;
      offset     <= '0;
      pend_pitch <= '0;
      tiled      <= 1'b0;
      pix4       <= 1'b0;
    end else if (wr) begin
      case (sel)
        RA_BASE:   pend_base  <= wdata;
        RA_OFFSET: offset     <= wdata;
        RA_PITCH:  pend_pitch <= wdata & PITCH_MASK;
        RA_MODE: begin
          tiled <= wdata[MODE_TILED_BIT];
          pix4  <= wdata[MODE_PIX4_BIT];
        end
        default: ;
      endcase
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      RA_BASE:   rd_mux = pend_base;
      RA_OFFSET: rd_mux = offset;
      RA_PITCH:  rd_mux = pend_pitch;
      RA_MODE: begin
        rd_mux[MODE_TILED_BIT] = tiled;
        rd_mux[MODE_PIX4_BIT]  = pix4;
        rd_mux[MODE_ARMED_BIT] = armed;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/ovl_shadow.sv
module ovl_shadow #(
  parameter int DATA_W    = 32,
  parameter int TILED_CAP = 16384,
  parameter bit CLAMP_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_wr,
  input  logic              vblank,
  input  logic [DATA_W-1:0] pend_base,
  input  logic [DATA_W-1:0] pend_pitch,
  input  logic              tiled,
  output logic [DATA_W-1:0] act_base,
  output logic [DATA_W-1:0] act_pitch,
  output logic              armed
);
  localparam logic [DATA_W-1:0] CAP_V = DATA_W'(TILED_CAP);

  logic [DATA_W-1:0] pitch_eff;

  generate
    if (CLAMP_EN) begin : g_clamp
      always_comb
        pitch_eff = (tiled && (pend_pitch > CAP_V)) ? CAP_V : pend_pitch;
    end else begin : g_pass
      always_comb pitch_eff = pend_pitch;
    end
  endgenerate

  logic load;
  assign load = armed && vblank;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_base  <= '0;
      act_pitch <= '0;
      armed     <= 1'b0;
    end else begin
      if (load) begin
        act_base  <= pend_base;
        act_pitch <= pitch_eff;
      end
      if (base_wr)   armed <= 1'b1;
      else if (load) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/ovl_addr_check.sv
module ovl_addr_check #(
  parameter int DATA_W    = 32,
  parameter int TILE_LSB  = 8,
  parameter int TILED_CAP = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] act_base,
  input  logic [DATA_W-1:0] offset,
  input  logic [DATA_W-1:0] pend_pitch,
  input  logic              tiled,
  input  logic              pix4,
  output logic [DATA_W-1:0] fetch_addr,
  output logic              cfg_err
);
  localparam logic [DATA_W-1:0] CAP_V = DATA_W'(TILED_CAP);

  logic tile_mis, tile_big, off_mis;

  always_comb begin
    tile_mis = tiled && (pend_pitch[TILE_LSB-1:0] != '0);
    tile_big = tiled && (pend_pitch > CAP_V);
    off_mis  = pix4 ? (offset[1:0] != 2'b00) : offset[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr <= '0;
      cfg_err    <= 1'b0;
    end else begin
      fetch_addr <= act_base + offset;
      cfg_err    <= tile_mis || tile_big || off_mis;
    end
  end
endmodule

// File: rtl/ovl_plane_regs.sv
module ovl_plane_regs #(
  parameter int DATA_W    = 32,
  parameter int PITCH_LSB = 6,
  parameter int TILE_LSB  = 8,
  parameter int TILED_CAP = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              vblank,
  output logic [DATA_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] act_stride,
  output logic              upd_armed,
  output logic              cfg_err
);
  logic [DATA_W-1:0] pend_base, offset, pend_pitch, act_base;
  logic              tiled, pix4, base_wr;

  ovl_regfile #(.DATA_W(DATA_W), .PITCH_LSB(PITCH_LSB)) u_rf (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .armed(upd_armed), .pend_base(pend_base), .offset(offset),
    .pend_pitch(pend_pitch), .tiled(tiled), .pix4(pix4),
    .base_wr(base_wr), .rdata(reg_rdata)
  );

  ovl_shadow #(.DATA_W(DATA_W), .TILED_CAP(TILED_CAP), .CLAMP_EN(1'b1)) u_sh (
    .clk(clk), .rst(rst), .base_wr(base_wr), .vblank(vblank),
    .pend_base(pend_base), .pend_pitch(pend_pitch), .tiled(tiled),
    .act_base(act_base), .act_pitch(act_stride), .armed(upd_armed)
  );

  ovl_addr_check #(.DATA_W(DATA_W), .TILE_LSB(TILE_LSB), .TILED_CAP(TILED_CAP)) u_ac (
    .clk(clk), .rst(rst), .act_base(act_base), .offset(offset),
    .pend_pitch(pend_pitch), .tiled(tiled), .pix4(pix4),
    .fetch_addr(fetch_addr), .cfg_err(cfg_err)
  );
endmodule

// File: rtl/ovl_plane_regs_chk.sv
module ovl_plane_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic              vblank,
  input logic              armed,
  input logic [DATA_W-1:0] act_stride,
  input logic [DATA_W-1:0] fetch_addr
);
  logic base_hit;
  assign base_hit = reg_wr && (reg_addr == 2'd0);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0 && act_stride == '0 && !armed));

  assert_arm_on_base_R3: assert property (@(posedge clk) disable iff (rst)
    base_hit |=> armed);

  assert_hold_armed_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && !vblank) |=> armed);

  assert_clear_on_blank_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && vblank && !base_hit) |=> !armed);

  assert_keep_on_collide_R12: assert property (@(posedge clk) disable iff (rst)
    (vblank && base_hit) |=> armed);

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!armed || !vblank) |=> $stable(act_stride));

  assert_pitch_grain_R8: assert property (@(posedge clk) disable iff (rst)
    act_stride[5:0] == 6'd0);
endmodule

bind ovl_plane_regs ovl_plane_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .vblank(vblank), .armed(upd_armed), .act_stride(act_stride),
  .fetch_addr(fetch_addr)
);

// File: tb/tb_ovl_plane_regs.sv
module tb_ovl_plane_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        vblank = 1'b0;
  logic [31:0] fetch_addr, act_stride;
  logic        upd_armed, cfg_err;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ovl_plane_regs dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vblank(vblank),
    .fetch_addr(fetch_addr), .act_stride(act_stride),
    .upd_armed(upd_armed), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic blank();
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 fetch", fetch_addr, 32'h0);
    chk("R1 stride", act_stride, 32'h0);
    chk("R1 armed", {31'h0, upd_armed}, 32'h0);
    chk("R1 err", {31'h0, cfg_err}, 32'h0);
    chk("R1 rdata", reg_rdata, 32'h0);

    // R8 reserved pitch bits
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, r);
    chk("R8 readback", r, 32'hFFFF_FFC0);

    // R2/R6 pitch alone does not reach active
    wr(2'd2, 32'h0000_1000);
    blank();
    settle();
    chk("R2 stride unchanged", act_stride, 32'h0);
    chk("R6 fetch unchanged", fetch_addr, 32'h0);

    // R3 arming and readback
    wr(2'd0, 32'h0010_0000);
    settle();
    chk("R3 armed", {31'h0, upd_armed}, 32'h1);
    rd(2'd3, r);
    chk("R3 mode bit2", r & 32'h4, 32'h4);
    chk("R3 not yet active", fetch_addr, 32'h0);

    // R4 apply on blank
    blank();
    chk("R4 armed clear", {31'h0, upd_armed}, 32'h0);
    chk("R4 stride", act_stride, 32'h0000_1000);
    @(negedge clk);
    chk("R4 base", fetch_addr, 32'h0010_0000);

    // R5 newest pending
    wr(2'd2, 32'h0000_0800);
    wr(2'd0, 32'h0020_0000);
    wr(2'd2, 32'h0000_0C00);
    wr(2'd0, 32'h0030_0000);
    blank();
    settle();
    chk("R5 base", fetch_addr, 32'h0030_0000);
    chk("R5 stride", act_stride, 32'h0000_0C00);

    // R12 collision: base write and blank together
    wr(2'd0, 32'h0040_0000);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0050_0000; vblank = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; vblank = 1'b0;
    @(negedge clk);
    chk("R12 old base", fetch_addr, 32'h0040_0000);
    chk("R12 still armed", {31'h0, upd_armed}, 32'h1);
    blank();
    settle();
    chk("R12 new base", fetch_addr, 32'h0050_0000);

    // R7 offset and wrap
    wr(2'd0, 32'hFFFF_FFF0);
    blank();
    wr(2'd1, 32'h0000_0020);
    settle();
    chk("R7 wrap sum", fetch_addr, 32'h0000_0010);

    // R11 offset alignment sweep, both pixel sizes
    wr(2'd0, 32'h1000_0000);
    wr(2'd2, 32'h0);
    blank();
    for (int p = 0; p < 2; p++) begin
      wr(2'd3, p[0] ? 32'h2 : 32'h0);
      for (int o = 0; o < 16; o++) begin
        wr(2'd1, 32'(o));
        settle();
        chk("R11 err", {31'h0, cfg_err},
            {31'h0, (p == 1) ? ((o % 4) != 0) : ((o % 2) != 0)});
        chk("R11/R7 low bits pass", fetch_addr, 32'h1000_0000 + 32'(o));
      end
    end
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h0);

    // R9/R10 pitch sweep in both modes
    for (int m = 0; m < 2; m++) begin
      wr(2'd3, 32'(m));
      for (int k = 0; k <= 300; k++) begin
        int pb;
        pb = k * 64;
        wr(2'd2, 32'(pb));
        wr(2'd0, 32'h2000_0000 + 32'(k));
        blank();
        settle();
        if (m == 0) begin
          chk("R9 linear no err", {31'h0, cfg_err}, 32'h0);
          chk("R9 linear stride", act_stride, 32'(pb));
        end else begin
          chk("R9/R10 tiled err", {31'h0, cfg_err},
              {31'h0, ((k % 4) != 0) || (pb > 16384)});
          chk("R10 tiled clamp", act_stride, 32'((pb > 16384) ? 16384 : pb));
        end
        chk("R4 base per step", fetch_addr, 32'h2000_0000 + 32'(k));
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule